// File: doc/BRIEF.md
# Row Delay Line with Subtract

This block delays a stream of 24-bit video samples by a whole number of clocks, the length of one video row, using a single-port memory of `DEPTH` words. An internal address counter walks the memory. On each clock the word at the current address is read out, and in the same cycle a sample from the input pipeline is written to that address. The delay therefore equals the length of the address loop plus the pipeline stages around the memory. The loop length is not held in a register. Instead, the controller pulses `restart_n` low once per row, and each pulse sends the counter back to address zero. If the pulses come every P clocks, the total delay is N = P + 4.

When `sub_mode` is high, the output register holds the delayed sample minus the input sample from three clocks earlier. The result is a row-to-row difference. After reset, the controller spends `DEPTH` clocks writing zero into every memory word. It then waits in an idle state until the first restart pulse. The controller has four named states: `ST_CLEAR` (memory sweep), `ST_IDLE` (waiting for the first restart), `ST_RUN` (counting and writing) and `ST_HOLD` (counter parked at the last address, writes off). Its transitions are as follows:
- `ST_CLEAR`→`ST_IDLE` when the sweep reaches the last address.
- `ST_IDLE`→`ST_RUN` on a restart.
- `ST_RUN`→`ST_HOLD` when the counter reaches the last address with no restart.
- `ST_HOLD`→`ST_RUN` on a restart.
- A restart inside `ST_RUN` leaves the state unchanged and sets the counter to zero.

Top module: `row_delay_sub`

## Requirements
- R1: While reset is asserted and for the `DEPTH` clocks after it is released, `pix_out` is zero, and every memory word is zero at the end of that sweep.
- R2: A clock edge that samples `restart_n` low loads the address counter with zero. Any other edge in the running state advances the counter by one. The restart never gates the memory write.
- R3: With `sub_mode` low and restart pulses every P clocks (2 ≤ P ≤ `DEPTH`), the output after edge C equals D(C−N+1), where N = P + 4 and D(k) is the input sampled at edge k. The delay range is therefore 6 to `DEPTH`+4 clocks.
- R4: In the first row after the memory sweep, the delayed term comes from cleared memory and is zero. This holds for outputs from the second edge after the first restart until a full row has passed.
- R5: With `sub_mode` high, the output after edge C equals D(C−N+1) − D(C−3), computed as 24-bit two's complement with wraparound. In the first row this is 0 − D(C−3).
- R6: If the counter reaches `DEPTH`−1 without a restart, it writes that last word once and then holds there with writes disabled. The output then repeats that word until the next restart.
- R7: When `out_en` is low, `pix_out` is zero. The pipeline and memory keep running, so the correct stream appears as soon as `out_en` returns high.
- R8: `sub_mode` is sampled at the same edge that loads the output register, so it can change on any cycle and affects only that cycle's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; starts the memory sweep |
| pix_in | input | 24 | Input sample, sampled every clock |
| restart_n | input | 1 | Active-low row restart; sends the address counter to zero |
| sub_mode | input | 1 | 1 = delayed minus recent sample, 0 = plain delay |
| out_en | input | 1 | 1 = drive the result, 0 = force the output to zero |
| pix_out | output | 24 | Registered delayed or difference sample (gated by `out_en`) |

## Verification
The assertions assume the following about the inputs:
- `restart_n` is a clean, known value at every edge.
- Restart pulses last one clock.
- Restart pulses are spaced no closer than two clocks and no further than `DEPTH` clocks apart, except when saturation is being exercised on purpose.

The properties about output values and counter steps rely on that spacing. The directed stimulus changes every input only on the falling clock edge, and it generates restart pulses from a fixed period per scenario. The one exception is the saturation scenario, which stops pulsing entirely. Input samples come from a deterministic function of the edge index. This lets every expected output be written directly from R3 and R5.

// File: rtl/rds_pkg.sv
package rds_pkg;

    // Sequencer states of the row delay controller.
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_RUN   = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_t;

    // Number of input pipeline stages ahead of the subtract tap.
    localparam int PIPE_STAGES = 3;

endpackage

// File: rtl/rds_addr_seq.sv
module rds_addr_seq
    import rds_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_n,
    output logic [AW-1:0] mem_addr,
    output logic          wr_en,
    output logic          clearing
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [AW-1:0] ONE       = AW'(1);

    seq_state_t    state, state_nxt;
    logic [AW-1:0] cnt, cnt_nxt;

    // State and counter register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEAR;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Next state and next address.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_CLEAR: begin
                if (cnt == LAST_ADDR) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + ONE;
                end
            end
            ST_IDLE: begin
                if (!restart_n) begin
                    state_nxt = ST_RUN;
                    cnt_nxt   = '0;
                end
            end
            ST_RUN: begin
                if (!restart_n) begin
                    cnt_nxt = '0;
                end else if (cnt == LAST_ADDR) begin
                    state_nxt = ST_HOLD;
                end else begin
                    cnt_nxt = cnt + ONE;
                end
            end
            ST_HOLD: begin
                if (!restart_n) begin
                    state_nxt = ST_RUN;
                    cnt_nxt   = '0;
                end
            end
            default: begin
                state_nxt = ST_CLEAR;
                cnt_nxt   = '0;
            end
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_addr = cnt;
        wr_en    = 1'b0;
        clearing = 1'b0;
        unique case (state)
            ST_CLEAR: begin
                wr_en    = 1'b1;
                clearing = 1'b1;
            end
            ST_RUN:  wr_en = 1'b1;
            ST_IDLE: wr_en = 1'b0;
            ST_HOLD: wr_en = 1'b0;
            default: wr_en = 1'b0;
        endcase
    end

    // R2
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_n && state != ST_CLEAR) |=> (cnt == '0));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && restart_n && cnt != LAST_ADDR) |=> (cnt == $past(cnt) + ONE));

    // R6
    park_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && restart_n && cnt == LAST_ADDR) |=> (state == ST_HOLD && cnt == LAST_ADDR));

    // R6
    park_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && restart_n) |=> ($stable(cnt) && !wr_en));

endmodule

// File: rtl/rds_line_mem.sv
module rds_line_mem #(
    parameter int W     = 24,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] store [DEPTH];

    // Read-before-write: rdata returns the word held before this edge's write.
    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        rdata <= store[addr];
    end

endmodule

// File: rtl/rds_datapath.sv
module rds_datapath
    import rds_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clearing,
    input  logic         sub_mode,
    input  logic [W-1:0] din,
    input  logic [W-1:0] rd_word,
    output logic [W-1:0] wr_word,
    output logic [W-1:0] dout_q
);

    localparam int WR_TAP  = PIPE_STAGES - 2;
    localparam int SUB_TAP = PIPE_STAGES - 1;

    logic [PIPE_STAGES-1:0][W-1:0] stg;

    // Input pipeline.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < PIPE_STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign wr_word = stg[WR_TAP];

    // Output register: plain delay or difference.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (clearing) begin
            dout_q <= '0;
        end else if (sub_mode) begin
            dout_q <= rd_word - stg[SUB_TAP];
        end else begin
            dout_q <= rd_word;
        end
    end

    // R1
    sweep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |=> (dout_q == '0));

    // R3
    plain_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clearing && !sub_mode) |=> (dout_q == $past(rd_word)));

    // R5
    diff_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clearing && sub_mode) |=> (dout_q + $past(stg[SUB_TAP]) == $past(rd_word)));

endmodule

// File: rtl/row_delay_sub.sv
module row_delay_sub #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 1024,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_in,
    input  logic              restart_n,
    input  logic              sub_mode,
    input  logic              out_en,
    output logic [DATA_W-1:0] pix_out
);

    logic [AW-1:0]     mem_addr;
    logic              wr_en;
    logic              clearing;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] dout_q;

    rds_addr_seq #(.DEPTH(DEPTH), .AW(AW)) seq_u (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_n (restart_n),
        .mem_addr  (mem_addr),
        .wr_en     (wr_en),
        .clearing  (clearing)
    );

    assign wr_data = clearing ? '0 : wr_word;

    rds_line_mem #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) mem_u (
        .clk   (clk),
        .we    (wr_en),
        .addr  (mem_addr),
        .wdata (wr_data),
        .rdata (rd_word)
    );

    rds_datapath #(.W(DATA_W)) dp_u (
        .clk      (clk),
        .rst_n    (rst_n),
        .clearing (clearing),
        .sub_mode (sub_mode),
        .din      (pix_in),
        .rd_word  (rd_word),
        .wr_word  (wr_word),
        .dout_q   (dout_q)
    );

    assign pix_out = out_en ? dout_q : '0;

    // R1
    sweep_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> (wr_en && wr_data == '0));

endmodule

// File: tb/row_delay_sub_tb.sv
module row_delay_sub_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 24;
    localparam int DEPTH      = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pix_in = '0;
    logic         restart_n = 1'b1;
    logic         sub_mode = 1'b0;
    logic         out_en = 1'b1;
    logic [W-1:0] pix_out;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    row_delay_sub #(.DATA_W(W), .DEPTH(DEPTH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_in    (pix_in),
        .restart_n (restart_n),
        .sub_mode  (sub_mode),
        .out_en    (out_en),
        .pix_out   (pix_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Sample applied at edge k.
    function automatic logic [W-1:0] pat(input int k);
        logic [31:0] t;
        t = 32'(k) * 32'(k) * 32'd2654435 + 32'(k) * 32'd40503 + 32'h5A5A5;
        return t[W-1:0];
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp_v);
        end
    endtask

    // R1: output zero in reset and during the sweep.
    task automatic t_reset_sweep();
        repeat (3) @(negedge clk);
        chk("R1 in reset", pix_out, '0);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            pix_in = pat(cyc + 1);
            if (i % 256 == 5) chk("R1 sweep", pix_out, '0);
        end
        repeat (2) begin
            @(negedge clk);
            pix_in = pat(cyc + 1);
        end
    endtask

    // Restart every period clocks; checks R3/R4/R5/R7/R8 depending on arguments.
    task automatic t_rows(input string tag, input int period, input int ncyc,
                          input bit sub, input bit alt, input bit first_row,
                          input int off_lo, input int off_hi);
        int  r0;
        bit  sub_at_edge;
        logic [W-1:0] delayed;
        logic [W-1:0] exp_v;
        r0 = cyc + 1;
        sub_at_edge = sub;
        for (int i = 0; i < ncyc; i++) begin
            if (i > 0) begin
                @(negedge clk);
                if (cyc >= r0 + 2 && (first_row || cyc >= r0 + period + 2)) begin
                    delayed = (cyc >= r0 + period + 2) ? pat(cyc - period - 3) : '0;
                    exp_v   = sub_at_edge ? (delayed - pat(cyc - 3)) : delayed;
                    if (!out_en) exp_v = '0;
                    chk(tag, pix_out, exp_v);
                end
            end
            restart_n = ((cyc + 1 - r0) % period == 0) ? 1'b0 : 1'b1;
            pix_in    = pat(cyc + 1);
            if (alt && i > 0) sub_mode = ~sub_mode;
            else if (i == 0)  sub_mode = sub;
            sub_at_edge = sub_mode;
            out_en = !(i >= off_lo && i < off_hi);
        end
        @(negedge clk);
        restart_n = 1'b1;
        out_en = 1'b1;
    endtask

    // R6: one restart, then none; counter parks on the last word.
    task automatic t_park();
        int r0;
        sub_mode  = 1'b0;
        restart_n = 1'b0;
        pix_in    = pat(cyc + 1);
        r0 = cyc + 1;
        for (int i = 0; i < DEPTH + 30; i++) begin
            @(negedge clk);
            restart_n = 1'b1;
            pix_in = pat(cyc + 1);
            if (cyc >= r0 + DEPTH + 2)
                chk("R6 parked output", pix_out, pat(r0 + DEPTH - 2));
        end
    endtask

    initial begin
        t_reset_sweep();
        // R4: first row comes from cleared memory; R3 at minimum delay 6 afterwards.
        t_rows("R4/R3 first row P2", 2, 30, 1'b0, 1'b0, 1'b1, -1, -1);
        // R3: delay 10.
        t_rows("R3 delay P6", 6, 40, 1'b0, 1'b0, 1'b0, -1, -1);
        // R5: N=10, output D(C-9) - D(C-3), wraps mod 2^24.
        t_rows("R5 subtract P6", 6, 60, 1'b1, 1'b0, 1'b0, -1, -1);
        // R3/R2: longest loop with full memory.
        t_rows("R3 delay P DEPTH", DEPTH, 2 * DEPTH + 20, 1'b0, 1'b0, 1'b0, -1, -1);
        // R7: gate output, stream intact after.
        t_rows("R7 out_en gate", 8, 50, 1'b0, 1'b0, 1'b0, 20, 27);
        // R8: mode toggles every cycle.
        t_rows("R8 mode per cycle", 7, 50, 1'b1, 1'b1, 1'b0, -1, -1);
        // R2: restart period change, odd length.
        t_rows("R2 restart P13 sub", 13, 60, 1'b1, 1'b0, 1'b0, -1, -1);
        t_park();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired at cycle %0d actual running expected finished", cyc);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule